// File: doc/BRIEF.md
# Bit-Serial Binary Crossbar Accumulator

This block is a digital model of an in-memory multiply-accumulate element that needs no converter stage. A matrix of one-bit cells, 36 rows by 256 columns by default, holds 8-bit signed weights. Each weight occupies eight neighbouring cells of one row, so the 256 columns form 32 weight columns. A window of 36 unsigned feature elements is latched at start. It is then applied to the rows one bit at a time: one row per clock, all rows for bit 0, then all rows for bit 1, and so on. A counter on every column counts the cycles in which the driven row bit is 1 and the cell under it is set.

At the end of each bit plane, the count of each column is shifted by the bit position and added into that column's accumulator. When the window ends, each group of eight column accumulators is weighted by cell significance, with the top cell taken as negative. This gives 32 two's-complement dot products, which appear together with a one-cycle done flag.

Weights are loaded through a simple write port while the block is idle. The caller presents the feature vector, pulses start, and waits for done. The window takes one clock for each feature bit of each row.

Top module: `xbar_pulse_mac`

## Requirements
- R1: After reset, busy_o and done_o are 0, every result field reads 0, and every cell is clear, so a window run before any write yields 0 in all 32 fields.
- R2: A write with wr_en_i high while the block is idle sets the eight cells of row wr_row_i, group wr_grp_i from wr_w_i at the next clock. Bit j of wr_w_i goes to column wr_grp_i*8+j. The value is a two's-complement weight.
- R3: Feature element r is the unsigned value feat_i[r*8 +: 8]. The whole vector is captured on the clock edge that accepts start. Later changes to feat_i do not affect that window.
- R4: Start is accepted on a clock edge where start_i is high and busy_o is low. busy_o is high from the cycle after acceptance until the done cycle, and is low in the done cycle.
- R5: done_o is high for exactly one cycle, on the 289th rising edge after the accepting edge (8 bits × 36 rows + 1).
- R6: Result field g, res_o[g*23 +: 23] read as signed, equals the sum over rows r of feature r times the signed weight at (r, g). This holds at the most negative and most positive extremes.
- R7: Result fields keep their value from one done cycle until the next done cycle.
- R8: A start pulse while busy_o is high is ignored: it neither restarts nor lengthens the running window. A write while busy_o is high is dropped and leaves the cells unchanged.
- R9: A start presented during the done cycle is accepted. The new window clears all column counters and accumulators, so its results depend only on its own features.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a window when idle |
| feat_i | input | 288 | Feature vector, 36 unsigned 8-bit elements, element r at bits r*8+7..r*8 |
| wr_en_i | input | 1 | Weight write strobe |
| wr_row_i | input | 6 | Row of the weight being written |
| wr_grp_i | input | 5 | Weight column (group of eight cells) being written |
| wr_w_i | input | 8 | Signed weight value |
| busy_o | output | 1 | Window in progress |
| done_o | output | 1 | One-cycle pulse: results valid and updated |
| res_o | output | 736 | 32 signed 23-bit dot products, field g at bits g*23+22..g*23 |

## Verification
A write becomes visible to the next window from the edge that samples it. A window's results and its done pulse are due exactly 289 rising edges after the edge that accepted start. The bench counts rising edges from the accepting edge and samples outputs 1 ns after each edge. It requires the first high done to fall on count 289 and compares all 32 fields in that same cycle. The busy-time start and write, the holding of results, and back-to-back windows are placed at known edge counts inside that window, so each expected value is tied to a particular cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    // bits to hold one bit-plane pulse count (0..rows)
    function automatic int cnt_width(input int rows);
        return $clog2(rows + 1);
    endfunction

    // bits to hold a column total across all bit planes
    function automatic int acc_width(input int rows, input int bx);
        return cnt_width(rows) + bx;
    endfunction

    // signed dot-product width for one weight column
    function automatic int res_width(input int rows, input int bx, input int grp);
        return acc_width(rows, bx) + grp + 1;
    endfunction

endpackage

// File: rtl/xbar_cell_store.sv
module xbar_cell_store #(
    parameter  int ROWS  = 36,
    parameter  int COLS  = 256,
    parameter  int GROUP = 8,
    localparam int NGRP  = COLS / GROUP,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [ROW_W-1:0] wr_row_i,
    input  logic [GRP_W-1:0] wr_grp_i,
    input  logic [GROUP-1:0] wr_w_i,
    input  logic [ROW_W-1:0] rd_row_i,
    output logic [COLS-1:0]  rd_bits_o
);

    logic [COLS-1:0] cell_d [ROWS];
    logic [COLS-1:0] cell_q [ROWS];

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            cell_d[r] = cell_q[r];
            if (wr_en_i && (wr_row_i == ROW_W'(r))) begin
                cell_d[r][int'(wr_grp_i)*GROUP +: GROUP] = wr_w_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) cell_q[r] <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) cell_q[r] <= cell_d[r];
        end
    end

    assign rd_bits_o = cell_q[rd_row_i];

endmodule

// File: rtl/xbar_bit_seq.sv
module xbar_bit_seq
    import xbar_pkg::*;
#(
    parameter  int ROWS  = 36,
    parameter  int BX    = 8,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int PL_W  = (BX > 1) ? $clog2(BX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ROWS*BX-1:0] feat_i,
    output logic               accept_o,
    output logic               busy_o,
    output logic               step_o,
    output logic [ROW_W-1:0]   row_o,
    output logic [PL_W-1:0]    plane_o,
    output logic               pulse_o,
    output logic               plane_end_o,
    output logic               fin_o
);

    typedef struct packed {
        seq_state_e         st;
        logic [ROW_W-1:0]   row;
        logic [PL_W-1:0]    plane;
        logic [ROWS*BX-1:0] feat;
    } seq_t;

    seq_t seq_d, seq_q;

    logic last_row, last_plane;

    always_comb begin
        seq_d      = seq_q;
        last_row   = (seq_q.row == ROW_W'(ROWS - 1));
        last_plane = (seq_q.plane == PL_W'(BX - 1));
        case (seq_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.st    = SEQ_RUN;
                    seq_d.row   = '0;
                    seq_d.plane = '0;
                    seq_d.feat  = feat_i;
                end
            end
            SEQ_RUN: begin
                if (last_row) begin
                    seq_d.row = '0;
                    if (last_plane) seq_d.st    = SEQ_FIN;
                    else            seq_d.plane = seq_q.plane + 1'b1;
                end else begin
                    seq_d.row = seq_q.row + 1'b1;
                end
            end
            SEQ_FIN:  seq_d.st = SEQ_IDLE;
            default:  seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, row: '0, plane: '0, feat: '0};
        else        seq_q <= seq_d;
    end

    assign accept_o    = (seq_q.st == SEQ_IDLE) && start_i;
    assign busy_o      = (seq_q.st != SEQ_IDLE);
    assign step_o      = (seq_q.st == SEQ_RUN);
    assign row_o       = seq_q.row;
    assign plane_o     = seq_q.plane;
    assign pulse_o     = step_o && seq_q.feat[int'(seq_q.row)*BX + int'(seq_q.plane)];
    assign plane_end_o = step_o && last_row;
    assign fin_o       = (seq_q.st == SEQ_FIN);

endmodule

// File: rtl/xbar_col_acc.sv
module xbar_col_acc
    import xbar_pkg::*;
#(
    parameter  int ROWS  = 36,
    parameter  int BX    = 8,
    localparam int CNT_W = cnt_width(ROWS),
    localparam int ACC_W = acc_width(ROWS, BX),
    localparam int PL_W  = (BX > 1) ? $clog2(BX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             hit_i,
    input  logic             plane_end_i,
    input  logic [PL_W-1:0]  plane_i,
    output logic [ACC_W-1:0] acc_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } col_t;

    col_t col_d, col_q;

    logic [CNT_W-1:0] cnt_inc;
    logic [ACC_W-1:0] weighted;

    always_comb begin
        col_d    = col_q;
        cnt_inc  = col_q.cnt + CNT_W'(hit_i);
        weighted = ACC_W'(cnt_inc) << plane_i;
        if (clear_i) begin
            col_d = '0;
        end else if (step_i) begin
            if (plane_end_i) begin
                col_d.acc = col_q.acc + weighted;
                col_d.cnt = '0;
            end else begin
                col_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign acc_o = col_q.acc;

endmodule

// File: rtl/xbar_group_sum.sv
module xbar_group_sum #(
    parameter int GROUP = 8,
    parameter int ACC_W = 14,
    parameter int RES_W = 23
) (
    input  logic [GROUP*ACC_W-1:0] acc_i,
    output logic signed [RES_W-1:0] sum_o
);

    logic signed [RES_W-1:0] total;
    logic signed [RES_W-1:0] term;

    always_comb begin
        total = '0;
        term  = '0;
        for (int j = 0; j < GROUP; j++) begin
            term = $signed({{(RES_W-ACC_W){1'b0}}, acc_i[j*ACC_W +: ACC_W]}) <<< j;
            // top cell of the group carries negative significance
            if (j == GROUP - 1) total = total - term;
            else                total = total + term;
        end
        sum_o = total;
    end

endmodule

// File: rtl/xbar_pulse_mac.sv
module xbar_pulse_mac
    import xbar_pkg::*;
#(
    parameter  int ROWS  = 36,
    parameter  int COLS  = 256,
    parameter  int GROUP = 8,
    parameter  int BX    = 8,
    localparam int NGRP  = COLS / GROUP,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int PL_W  = (BX > 1) ? $clog2(BX) : 1,
    localparam int ACC_W = acc_width(ROWS, BX),
    localparam int RES_W = res_width(ROWS, BX, GROUP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [ROWS*BX-1:0]    feat_i,
    input  logic                  wr_en_i,
    input  logic [ROW_W-1:0]      wr_row_i,
    input  logic [GRP_W-1:0]      wr_grp_i,
    input  logic [GROUP-1:0]      wr_w_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [NGRP*RES_W-1:0] res_o
);

    logic               accept, busy, step, pulse, plane_end, fin;
    logic [ROW_W-1:0]   row;
    logic [PL_W-1:0]    plane;
    logic [COLS-1:0]    rd_bits;
    logic [COLS-1:0]    hit;
    logic [COLS*ACC_W-1:0] acc_all;
    logic [NGRP*RES_W-1:0] grp_sum;

    xbar_bit_seq #(.ROWS(ROWS), .BX(BX)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .feat_i      (feat_i),
        .accept_o    (accept),
        .busy_o      (busy),
        .step_o      (step),
        .row_o       (row),
        .plane_o     (plane),
        .pulse_o     (pulse),
        .plane_end_o (plane_end),
        .fin_o       (fin)
    );

    xbar_cell_store #(.ROWS(ROWS), .COLS(COLS), .GROUP(GROUP)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i && !busy),
        .wr_row_i  (wr_row_i),
        .wr_grp_i  (wr_grp_i),
        .wr_w_i    (wr_w_i),
        .rd_row_i  (row),
        .rd_bits_o (rd_bits)
    );

    assign hit = rd_bits & {COLS{pulse}};

    for (genvar c = 0; c < COLS; c++) begin : g_col
        xbar_col_acc #(.ROWS(ROWS), .BX(BX)) u_col (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear_i     (accept),
            .step_i      (step),
            .hit_i       (hit[c]),
            .plane_end_i (plane_end),
            .plane_i     (plane),
            .acc_o       (acc_all[c*ACC_W +: ACC_W])
        );
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        xbar_group_sum #(.GROUP(GROUP), .ACC_W(ACC_W), .RES_W(RES_W)) u_sum (
            .acc_i (acc_all[g*GROUP*ACC_W +: GROUP*ACC_W]),
            .sum_o (grp_sum[g*RES_W +: RES_W])
        );
    end

    typedef struct packed {
        logic                  done;
        logic [NGRP*RES_W-1:0] res;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.done = fin;
        if (fin) out_d.res = grp_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign busy_o = busy;
    assign done_o = out_q.done;
    assign res_o  = out_q.res;

endmodule

// File: rtl/xbar_pulse_mac_chk.sv
module xbar_pulse_mac_chk #(
    parameter int ROWS    = 36,
    parameter int BX      = 8,
    parameter int RES_TOT = 736
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [RES_TOT-1:0] res_o
);

    localparam int WIN = ROWS * BX + 1;

    logic        run_q;
    logic [31:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            run_q <= 1'b1;
            lat_q <= '0;
        end else if (done_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q && (lat_q == 32'(WIN))));

    // R4
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !done_o) |-> busy_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(res_o));

endmodule

bind xbar_pulse_mac xbar_pulse_mac_chk #(
    .ROWS    (ROWS),
    .BX      (BX),
    .RES_TOT (NGRP*RES_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .res_o   (res_o)
);

// File: tb/xbar_pulse_mac_test.sv
`timescale 1ns/1ps
module xbar_pulse_mac_test;
    import xbar_pkg::*;

    localparam int ROWS  = 36;
    localparam int COLS  = 256;
    localparam int GROUP = 8;
    localparam int BX    = 8;
    localparam int NGRP  = COLS / GROUP;
    localparam int RES_W = res_width(ROWS, BX, GROUP);
    localparam int WIN   = ROWS * BX + 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start_i = 1'b0;
    logic [ROWS*BX-1:0]    feat_i = '0;
    logic                  wr_en_i = 1'b0;
    logic [5:0]            wr_row_i = '0;
    logic [4:0]            wr_grp_i = '0;
    logic [7:0]            wr_w_i = '0;
    logic                  busy_o, done_o;
    logic [NGRP*RES_W-1:0] res_o;

    int total = 0;
    int bad   = 0;
    int wm [ROWS][NGRP];

    always #5 clk = ~clk;

    xbar_pulse_mac uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .feat_i(feat_i),
        .wr_en_i(wr_en_i), .wr_row_i(wr_row_i), .wr_grp_i(wr_grp_i), .wr_w_i(wr_w_i),
        .busy_o(busy_o), .done_o(done_o), .res_o(res_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint field(input int g);
        logic signed [RES_W-1:0] v;
        v = res_o[g*RES_W +: RES_W];
        return longint'(v);
    endfunction

    function automatic longint expect_dot(input logic [ROWS*BX-1:0] f, input int g);
        longint s = 0;
        for (int r = 0; r < ROWS; r++) s += longint'(int'(f[r*BX +: BX])) * wm[r][g];
        return s;
    endfunction

    task automatic check_all(input logic [ROWS*BX-1:0] f, input string req);
        for (int g = 0; g < NGRP; g++)
            chk(field(g) == expect_dot(f, g), req, $sformatf("field %0d", g),
                field(g), expect_dot(f, g));
    endtask

    // idle-time write; model follows only accepted writes
    task automatic write_w(input int r, input int g, input int w);
        @(negedge clk);
        wr_en_i = 1'b1; wr_row_i = 6'(r); wr_grp_i = 5'(g); wr_w_i = 8'(w);
        wm[r][g] = int'($signed(8'(w)));
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic fill(input int mode);
        for (int r = 0; r < ROWS; r++)
            for (int g = 0; g < NGRP; g++) begin
                if (mode == 0)      write_w(r, g, ((r*7 + g*13) % 256) - 128);
                else if (mode == 1) write_w(r, g, -128);
                else                write_w(r, g, 127);
            end
    endtask

    task automatic kick(input logic [ROWS*BX-1:0] f);
        @(negedge clk);
        feat_i = f; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic await_done(inout int k);
        while (!done_o && k < WIN + 20) begin
            @(posedge clk); #1;
            k++;
        end
    endtask

    task automatic run_window(input logic [ROWS*BX-1:0] f, input string req);
        int k = 0;
        kick(f);
        chk(busy_o == 1'b1, "R4", "busy after start", busy_o, 1);
        await_done(k);
        chk(k == WIN, "R5", "done latency", k, WIN);
        check_all(f, req);
    endtask

    function automatic logic [ROWS*BX-1:0] pattern(input int seed);
        logic [ROWS*BX-1:0] f;
        for (int r = 0; r < ROWS; r++) f[r*BX +: BX] = 8'((r*29 + seed*11 + 5) % 256);
        return f;
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(busy_o == 1'b0, "R1", "busy at reset", busy_o, 0);
        chk(done_o == 1'b0, "R1", "done at reset", done_o, 0);
        chk(res_o == '0, "R1", "results at reset", (res_o == '0) ? 0 : 1, 0);
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++) for (int g = 0; g < NGRP; g++) wm[r][g] = 0;
        run_window({ROWS*BX{1'b1}}, "R1");
    endtask

    task automatic t_basic;
        fill(0);
        run_window(pattern(1), "R6");
        run_window(pattern(2), "R2");
    endtask

    task automatic t_extremes;
        fill(1);
        run_window({ROWS*BX{1'b1}}, "R6");
        chk(field(5) == -longint'(ROWS*255*128), "R6", "most negative", field(5), -longint'(ROWS*255*128));
        fill(2);
        run_window({ROWS*BX{1'b1}}, "R6");
        chk(field(9) == longint'(ROWS*255*127), "R6", "most positive", field(9), longint'(ROWS*255*127));
    endtask

    task automatic t_busy_ignore;
        logic [ROWS*BX-1:0] f1;
        int k = 0;
        int old0;
        fill(0);
        f1 = pattern(3);
        old0 = wm[0][0];
        kick(f1);
        @(negedge clk);
        feat_i = pattern(4); start_i = 1'b1;
        wr_en_i = 1'b1; wr_row_i = '0; wr_grp_i = '0; wr_w_i = 8'(old0) ^ 8'h55;
        @(posedge clk); #1;
        k = 1;
        @(negedge clk);
        start_i = 1'b0; wr_en_i = 1'b0;
        await_done(k);
        chk(k == WIN, "R8", "latency with busy start", k, WIN);
        check_all(f1, "R3");
        @(posedge clk); #1;
        chk(busy_o == 1'b0, "R8", "no restart after done", busy_o, 0);
        run_window(f1, "R8");
    endtask

    task automatic t_hold;
        logic [NGRP*RES_W-1:0] snap;
        run_window(pattern(5), "R6");
        snap = res_o;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            chk(done_o == 1'b0, "R5", "done single cycle", done_o, 0);
            chk(res_o == snap, "R7", "results held", (res_o == snap) ? 0 : 1, 0);
        end
    endtask

    task automatic t_back2back;
        logic [ROWS*BX-1:0] f2;
        int k = 0;
        run_window({ROWS*BX{1'b1}}, "R6");
        f2 = pattern(6);
        feat_i = f2; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "start in done cycle", busy_o, 1);
        await_done(k);
        chk(k == WIN, "R9", "second latency", k, WIN);
        check_all(f2, "R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_extremes();
        t_busy_ignore();
        t_hold();
        t_back2back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule